// File: doc/BRIEF.md
# Transmit Clock Loss Monitor and Source Selector

This block supervises the transmit input clock from a free-running system clock. The monitored clock is brought into the system domain through a synchroniser, and every transition of the synchronised level counts as activity. When no transition is seen for a programmable number of system clock cycles, a loss status is raised. It is withdrawn only after a programmable number of transitions have arrived again with no long gap between them, so a clock that stutters does not make the status chatter. Each change of the status also produces a one-cycle pulse that can be latched as an interrupt.

From the status, a fail-over enable and two loopback controls, the block derives two registered select bits. These select bits drive an external glitch-free clock multiplexer. One picks the source of the internal transmit clock. The other picks the source of the transmit clock output. A select value of 1 picks the receive clock and 0 picks the transmit input clock. The clocks themselves never pass through this block. All control inputs are plain levels, synchronous to the system clock. Nothing in the block streams data, so it has no valid/ready interface and no back-pressure.

Top module: `txclk_guard`

## Requirements
- R1: While rst_n is low, and on the first cycle after its release, loss, loss_chg, int_sel_rx and out_sel_rx are all 0.
- R2: Both rising and falling transitions of tx_in_clk count as activity. A level first sampled at system clock edge k takes effect at edge k+2, after two synchroniser stages and one edge-detect stage.
- R3: loss rises at the edge where LOSS_CYC consecutive system cycles (default 8) have passed with no detected transition. Transitions spaced LOSS_CYC cycles apart, or closer, never raise it.
- R4: While loss is high, it falls at the edge that handles the RECOV_EDGES-th detected transition (default 4). The transition count restarts from zero whenever LOSS_CYC cycles pass without a transition.
- R5: loss_chg is high for exactly the one cycle in which loss takes a new value, and is low at all other times.
- R6: int_sel_rx is 0 (transmit input clock) when payload loopback is off and either loss or failover_en is low.
- R7: One cycle after loss and failover_en are both high, int_sel_rx is 1 (receive clock). With failover_en low, loss has no effect on either select.
- R8: One cycle after pay_lpbk is high, int_sel_rx is 1, whatever the loss status.
- R9: out_sel_rx follows int_sel_rx, except that one cycle after line_lpbk is high it is 1. line_lpbk has no effect on int_sel_rx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_in_clk | input | 1 | Monitored transmit input clock, asynchronous to clk |
| failover_en | input | 1 | Allows a switch to the receive clock on loss |
| pay_lpbk | input | 1 | Payload loopback: internal transmit clock from the receive clock |
| line_lpbk | input | 1 | Line loopback: clock output from the receive clock |
| loss | output | 1 | Loss-of-transmit-clock status level |
| loss_chg | output | 1 | One-cycle pulse on each change of loss |
| int_sel_rx | output | 1 | Internal transmit clock select, 1 = receive clock |
| out_sel_rx | output | 1 | Transmit clock output select, 1 = receive clock |

## Verification
The hardest cases to reach from the ports are at the hysteresis boundaries. One is a transmit clock whose transitions come exactly LOSS_CYC cycles apart, which must never raise loss. Another is one slower by a single cycle, which must raise loss and keep resetting the recovery count so that loss never clears. The bench drives tx_in_clk from a toggler with a programmable half-period in system cycles. Directed phases sit on both sides of that boundary, and each recovery count is reached only after a full loss. Random phases then mix half-periods, stops and control settings, and a cycle-accurate model built from the requirements is compared against every output on every cycle.

// File: rtl/txclk_guard_pkg.sv
package txclk_guard_pkg;

  // Encoding of a clock source select bit.
  typedef enum logic {
    SRC_TX = 1'b0,
    SRC_RX = 1'b1
  } clk_src_e;

endpackage

// File: rtl/txclk_sync.sv
module txclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_async;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/txclk_loss_det.sv
module txclk_loss_det #(
  parameter int LOSS_CYC    = 8,
  parameter int RECOV_EDGES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_sync,
  output logic loss_q,
  output logic chg_q
);

  localparam int GAP_W = $clog2(LOSS_CYC + 1);
  localparam int REC_W = $clog2(RECOV_EDGES + 1);
  localparam logic [GAP_W-1:0] GAP_MAX  = GAP_W'(LOSS_CYC);
  localparam logic [REC_W-1:0] REC_LAST = REC_W'(RECOV_EDGES - 1);

  logic             prev_q;
  logic             act;
  logic [GAP_W-1:0] gap_q, gap_nx;
  logic [REC_W-1:0] rec_q, rec_nx;
  logic             loss_nx;

  assign act = lvl_sync ^ prev_q;

  always_comb begin
    if (act)                  gap_nx = '0;
    else if (gap_q == GAP_MAX) gap_nx = gap_q;
    else                      gap_nx = gap_q + 1'b1;

    loss_nx = loss_q;
    rec_nx  = rec_q;
    if (!loss_q) begin
      loss_nx = (gap_nx == GAP_MAX);
      rec_nx  = '0;
    end else if (act) begin
      if (rec_q == REC_LAST) begin
        loss_nx = 1'b0;
        rec_nx  = '0;
      end else begin
        rec_nx = rec_q + 1'b1;
      end
    end else if (gap_nx == GAP_MAX) begin
      rec_nx = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      gap_q  <= '0;
      rec_q  <= '0;
      loss_q <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      prev_q <= lvl_sync;
      gap_q  <= gap_nx;
      rec_q  <= rec_nx;
      loss_q <= loss_nx;
      chg_q  <= loss_nx ^ loss_q;
    end
  end

endmodule

// File: rtl/txclk_src_sel.sv
module txclk_src_sel
  import txclk_guard_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     loss,
  input  logic     failover_en,
  input  logic     pay_lpbk,
  input  logic     line_lpbk,
  output clk_src_e int_src,
  output clk_src_e out_src
);

  clk_src_e int_nx, out_nx;

  always_comb begin
    int_nx = SRC_TX;
    if (pay_lpbk || (loss && failover_en)) int_nx = SRC_RX;
    out_nx = line_lpbk ? SRC_RX : int_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_src <= SRC_TX;
      out_src <= SRC_TX;
    end else begin
      int_src <= int_nx;
      out_src <= out_nx;
    end
  end

endmodule

// File: rtl/txclk_guard.sv
module txclk_guard
  import txclk_guard_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOSS_CYC    = 8,
  parameter int RECOV_EDGES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_in_clk,
  input  logic failover_en,
  input  logic pay_lpbk,
  input  logic line_lpbk,
  output logic loss,
  output logic loss_chg,
  output logic int_sel_rx,
  output logic out_sel_rx
);

  logic     lvl_sync;
  clk_src_e int_src, out_src;

  txclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (tx_in_clk),
    .q_sync  (lvl_sync)
  );

  txclk_loss_det #(.LOSS_CYC(LOSS_CYC), .RECOV_EDGES(RECOV_EDGES)) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl_sync (lvl_sync),
    .loss_q   (loss),
    .chg_q    (loss_chg)
  );

  txclk_src_sel u_sel (
    .clk         (clk),
    .rst_n       (rst_n),
    .loss        (loss),
    .failover_en (failover_en),
    .pay_lpbk    (pay_lpbk),
    .line_lpbk   (line_lpbk),
    .int_src     (int_src),
    .out_src     (out_src)
  );

  assign int_sel_rx = (int_src == SRC_RX);
  assign out_sel_rx = (out_src == SRC_RX);

endmodule

// File: rtl/txclk_guard_chk.sv
module txclk_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic failover_en,
  input logic pay_lpbk,
  input logic line_lpbk,
  input logic loss,
  input logic loss_chg,
  input logic int_sel_rx,
  input logic out_sel_rx
);

  assert_chg_marks_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    loss_chg |-> (loss != $past(loss)));

  assert_toggle_has_chg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (loss != $past(loss)) |-> loss_chg);

  assert_normal_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pay_lpbk && !(loss && failover_en)) |=> !int_sel_rx);

  assert_failover_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (loss && failover_en) |=> int_sel_rx);

  assert_payload_lpbk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pay_lpbk |=> int_sel_rx);

  assert_out_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int_sel_rx |-> out_sel_rx);

  assert_line_lpbk_R9: assert property (@(posedge clk) disable iff (!rst_n)
    line_lpbk |=> out_sel_rx);

endmodule

bind txclk_guard txclk_guard_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .failover_en (failover_en),
  .pay_lpbk    (pay_lpbk),
  .line_lpbk   (line_lpbk),
  .loss        (loss),
  .loss_chg    (loss_chg),
  .int_sel_rx  (int_sel_rx),
  .out_sel_rx  (out_sel_rx)
);

// File: tb/test_txclk_guard.sv
`timescale 1ns/1ps
module test_txclk_guard;

  localparam int L = 8;
  localparam int R = 4;

  logic clk = 0, rst_n = 0, tx_in_clk = 0;
  logic failover_en = 0, pay_lpbk = 0, line_lpbk = 0;
  logic loss, loss_chg, int_sel_rx, out_sel_rx;

  int checks = 0, errors = 0, cyc = 0, half = 0, ph = 0;
  bit done = 0;

  always #2 clk = ~clk;

  txclk_guard i_txclk_guard (
    .clk(clk), .rst_n(rst_n), .tx_in_clk(tx_in_clk),
    .failover_en(failover_en), .pay_lpbk(pay_lpbk), .line_lpbk(line_lpbk),
    .loss(loss), .loss_chg(loss_chg), .int_sel_rx(int_sel_rx), .out_sel_rx(out_sel_rx)
  );

  // tx clock toggler: level flips every 'half' system cycles, stopped when 0
  always @(negedge clk) begin
    if (rst_n && half != 0) begin
      if (ph >= half - 1) begin tx_in_clk <= ~tx_in_clk; ph <= 0; end
      else ph <= ph + 1;
    end else ph <= 0;
  end

  // Reference model from the requirements (R2 latency, R3/R4 hysteresis)
  logic h1 = 0, h2 = 0, h3 = 0;
  int   m_gap = 0, m_rec = 0;
  logic m_loss = 0, m_chg = 0, m_int = 0, m_out = 0;
  logic e, ln;
  int   gn, rn;

  always @(posedge clk) begin
    if (!rst_n) begin
      h1 <= 0; h2 <= 0; h3 <= 0; m_gap <= 0; m_rec <= 0;
      m_loss <= 0; m_chg <= 0; m_int <= 0; m_out <= 0;
    end else begin
      e  = h2 ^ h3;
      gn = e ? 0 : ((m_gap == L) ? L : m_gap + 1);
      ln = m_loss; rn = m_rec;
      if (!m_loss) begin ln = (gn == L); rn = 0; end
      else if (e) begin
        if (m_rec == R - 1) begin ln = 0; rn = 0; end else rn = m_rec + 1;
      end else if (gn == L) rn = 0;
      h1 <= tx_in_clk; h2 <= h1; h3 <= h2;
      m_gap <= gn; m_rec <= rn; m_loss <= ln; m_chg <= (ln != m_loss);
      m_int <= pay_lpbk | (m_loss & failover_en);
      m_out <= line_lpbk | pay_lpbk | (m_loss & failover_en);
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      if (errors < 30) $display("FAIL %s at cycle %0d: got %b expected %b", req, cyc, act, exp);
    end
  endtask

  // continuous comparison, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      chk("R2 R3 R4 loss", loss, m_loss);
      chk("R5 loss_chg", loss_chg, m_chg);
      chk("R6 R7 R8 int_sel_rx", int_sel_rx, m_int);
      chk("R9 out_sel_rx", out_sel_rx, m_out);
    end
    if (cyc > 100000 && !done) begin
      errors++; done = 1;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    run(3);
    chk("R1 loss in reset", loss, 0);
    chk("R1 chg in reset", loss_chg, 0);
    chk("R1 int_sel in reset", int_sel_rx, 0);
    chk("R1 out_sel in reset", out_sel_rx, 0);
    rst_n = 1;
    run(1);
    chk("R1 loss after release", loss, 0);
    chk("R1 out_sel after release", out_sel_rx, 0);

    // R2/R3: fast clock keeps loss low
    half = 1; run(40);
    chk("R3 no loss with active clock", loss, 0);
    // R3: stop, loss raised; failover off so R7 no switch
    half = 0; run(20);
    chk("R3 loss after idle", loss, 1);
    chk("R7 no switch without failover", int_sel_rx, 0);
    failover_en = 1; run(2);
    chk("R7 switch on loss with failover", int_sel_rx, 1);
    chk("R9 out follows int", out_sel_rx, 1);
    // R4: recovery
    half = 3; run(40);
    chk("R4 recovered", loss, 0);
    chk("R6 back to tx source", int_sel_rx, 0);
    // R3 boundary: transitions exactly L apart never raise loss
    half = L; run(120);
    chk("R3 spacing L keeps loss low", loss, 0);
    // one cycle slower: loss raised and recovery count keeps restarting (R4)
    half = L + 1; run(150);
    chk("R4 spacing L+1 never recovers", loss, 1);
    // R8: payload loopback
    failover_en = 0; pay_lpbk = 1; run(2);
    chk("R8 payload loopback", int_sel_rx, 1);
    half = 1; run(30);
    chk("R8 payload loopback independent of loss", int_sel_rx, 1);
    pay_lpbk = 0; line_lpbk = 1; run(2);
    chk("R9 line loopback on out", out_sel_rx, 1);
    chk("R9 line loopback leaves int", int_sel_rx, 0);
    line_lpbk = 0; run(2);

    // constrained random phases
    for (int p = 0; p < 150; p++) begin
      int r;
      r = $urandom_range(0, 12);
      half = (r > 10) ? 0 : (r == 10 ? L + 1 : r + 1);
      failover_en = $urandom_range(0, 1);
      pay_lpbk    = ($urandom_range(0, 3) == 0);
      line_lpbk   = ($urandom_range(0, 3) == 0);
      run($urandom_range(10, 60));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule